// File: doc/BRIEF.md
# Scalable 64-bit System Counter

This block produces a 64-bit system count value for the timer frames of a chip. The count advances on a reference tick input (`tick_i`), which is sampled on every rising clock edge. Software drives the block through a small memory-mapped register port. Through that port it can start and stop counting, load either 32-bit half of the count, and read back the control, status, count and scale registers.

When scaling is turned on, each tick adds an unsigned 8.24 fixed-point increment instead of exactly one. A 24-bit fractional accumulator carries the leftover fraction from one tick to the next. This lets a tick source of one frequency produce a count that runs at a slower or faster rate. The full count is always present on `count_o`.

Writes take effect on the clock edge at which `wr_en_i` is high. Reads are combinational from `addr_i` to `rdata_o`.

Top module: `sc_counter_top`

## Requirements
- R1: After reset the counter is stopped, the count is 0, the control register reads 0, the scale register reads 0x01000000 and the status register reads 1.
- R2: While the counter is stopped, ticks leave the count unchanged.
- R3: With the counter running and scaling off, each clock edge with `tick_i` high adds exactly 1 to the count, so 100 ticks give 100.
- R4: With scaling on, each tick adds floor((frac + scale) / 2^24) to the count and keeps the low 24 bits as the new fraction. A scale of 0x00100000 adds 10 over 160 ticks, and a scale of 0x02800000 adds 10 over 4 ticks.
- R5: The control register is at offset 0x00. Bit 0 enables counting and bit 2 enables scaling, so writing 5 runs the counter with scaling. Both bits read back at those positions and every other bit reads 0.
- R6: The count low half is at offset 0x08 and the high half at offset 0x0C. A write replaces only the addressed half. Both halves read back, and a carry out of the low half goes into the high half.
- R7: A write to either count half, or an accepted write to the scale register, clears the fractional accumulator.
- R8: The scale register is at offset 0x10. A write to it while the counter is enabled is ignored.
- R9: The status register is at offset 0x04. Its bit 0 reads 1 while the counter is stopped and 0 while it runs.
- R10: A count write in the same cycle as a tick wins: the written half takes the written value and the tick is lost.
- R11: A read of any offset that is not mapped returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Reference tick, one tick per clock edge at which it is high |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 5 | Register byte offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i` |
| count_o | output | 64 | Current count value |

## Verification
The bench builds the block with its default parameters: a 64-bit count, a 32-bit register port, and an 8.24 scale with a 24-bit fraction. With these widths the cases below can be tested in a few clock cycles:
- the exact one-sixteenth rate;
- a scale above one that carries a fraction (2.5);
- a scale of one half, which shows whether the accumulator was cleared.

Loading the low half just below its wrap point makes the carry into the high half appear within three ticks.

// File: rtl/sc_pkg.sv
package sc_pkg;
  // Register byte offsets (software-visible map)
  localparam int SC_OFF_CTRL   = 'h00;
  localparam int SC_OFF_STAT   = 'h04;
  localparam int SC_OFF_CNT_LO = 'h08;
  localparam int SC_OFF_CNT_HI = 'h0C;
  localparam int SC_OFF_SCALE  = 'h10;

  // Control bit positions
  localparam int SC_BIT_RUN   = 0;
  localparam int SC_BIT_SCALE = 2;

  typedef struct packed {
    logic run;
    logic scale_on;
  } sc_ctrl_t;
endpackage

// File: rtl/sc_regs.sv
module sc_regs
  import sc_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 5,
  parameter int CNT_W       = 64,
  parameter int SCALE_W     = 32,
  parameter logic [SCALE_W-1:0] SCALE_RST = 32'h0100_0000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  input  logic [CNT_W-1:0]   count_i,
  output sc_ctrl_t           ctrl_o,
  output logic [SCALE_W-1:0] scale_o,
  output logic               lo_wr_o,
  output logic               hi_wr_o,
  output logic               scale_load_o,
  output logic [DATA_W-1:0]  rdata_o
);
  sc_ctrl_t           ctrl_q;
  logic [SCALE_W-1:0] scale_q;
  logic               ctrl_wr;
  logic               scale_wr;

  // Address decode for the write side
  assign ctrl_wr      = wr_en_i && (addr_i == ADDR_W'(SC_OFF_CTRL));
  assign scale_wr     = wr_en_i && (addr_i == ADDR_W'(SC_OFF_SCALE));
  assign lo_wr_o      = wr_en_i && (addr_i == ADDR_W'(SC_OFF_CNT_LO));
  assign hi_wr_o      = wr_en_i && (addr_i == ADDR_W'(SC_OFF_CNT_HI));
  // The scale register only takes a new value while counting is stopped
  assign scale_load_o = scale_wr && !ctrl_q.run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      scale_q <= SCALE_RST;
    end else begin
      if (ctrl_wr) begin
        ctrl_q.run      <= wdata_i[SC_BIT_RUN];
        ctrl_q.scale_on <= wdata_i[SC_BIT_SCALE];
      end
      if (scale_load_o) scale_q <= SCALE_W'(wdata_i);
    end
  end

  assign ctrl_o  = ctrl_q;
  assign scale_o = scale_q;

  // Combinational read mux
  always_comb begin
    rdata_o = '0;
    case (addr_i)
      ADDR_W'(SC_OFF_CTRL): begin
        rdata_o[SC_BIT_RUN]   = ctrl_q.run;
        rdata_o[SC_BIT_SCALE] = ctrl_q.scale_on;
      end
      ADDR_W'(SC_OFF_STAT):   rdata_o[0] = !ctrl_q.run;
      ADDR_W'(SC_OFF_CNT_LO): rdata_o = count_i[DATA_W-1:0];
      ADDR_W'(SC_OFF_CNT_HI): rdata_o = count_i[CNT_W-1:DATA_W];
      ADDR_W'(SC_OFF_SCALE):  rdata_o = DATA_W'(scale_q);
      default:                rdata_o = '0;
    endcase
  end

  // R8: the scale register holds its value while the counter runs
  a_r8_scale_locked: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q.run |=> $stable(scale_q));
endmodule

// File: rtl/sc_accum.sv
module sc_accum #(
  parameter int SCALE_W = 32,
  parameter int FRAC_W  = 24,
  localparam int INC_W  = SCALE_W - FRAC_W + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               step_i,
  input  logic               clear_i,
  input  logic [SCALE_W-1:0] scale_i,
  output logic [INC_W-1:0]   inc_o
);
  logic [FRAC_W-1:0] frac_q;
  logic [FRAC_W-1:0] frac_nxt;

  // Integer part of (fraction + scale) is the step; the rest carries on
  function automatic logic [INC_W+FRAC_W-1:0] scaled_sum(
    input logic [FRAC_W-1:0] frac, input logic [SCALE_W-1:0] scl);
    return (INC_W+FRAC_W)'(frac) + (INC_W+FRAC_W)'(scl);
  endfunction

  always_comb begin
    logic [INC_W+FRAC_W-1:0] sum;
    sum      = scaled_sum(frac_q, scale_i);
    inc_o    = sum[INC_W+FRAC_W-1:FRAC_W];
    frac_nxt = sum[FRAC_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       frac_q <= '0;
    else if (clear_i) frac_q <= '0;
    else if (step_i)  frac_q <= frac_nxt;
  end

  // R7: clearing events leave an empty fraction
  a_r7_frac_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> (frac_q == '0));
endmodule

// File: rtl/sc_count.sv
module sc_count #(
  parameter int CNT_W  = 64,
  parameter int DATA_W = 32,
  parameter int INC_W  = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv_i,
  input  logic [INC_W-1:0]  amt_i,
  input  logic              lo_wr_i,
  input  logic              hi_wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [CNT_W-1:0]  count_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (lo_wr_i) begin
      cnt_q[DATA_W-1:0] <= wdata_i;
    end else if (hi_wr_i) begin
      cnt_q[CNT_W-1:DATA_W] <= (CNT_W-DATA_W)'(wdata_i);
    end else if (adv_i) begin
      cnt_q <= cnt_q + CNT_W'(amt_i);
    end
  end

  assign count_o = cnt_q;

  // R10: a low-half write lands exactly as written
  a_r10_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    lo_wr_i |=> (cnt_q[DATA_W-1:0] == $past(wdata_i)));
endmodule

// File: rtl/sc_counter_top.sv
module sc_counter_top
  import sc_pkg::*;
#(
  parameter int CNT_W   = 64,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 5,
  parameter int SCALE_W = 32,
  parameter int FRAC_W  = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [CNT_W-1:0]  count_o
);
  localparam int INC_W = SCALE_W - FRAC_W + 1;

  sc_ctrl_t           ctrl;
  logic [SCALE_W-1:0] scale;
  logic               lo_wr, hi_wr, scale_load;
  logic               cnt_wr;
  logic               advance;
  logic               frac_step;
  logic [INC_W-1:0]   scaled_inc;
  logic [INC_W-1:0]   step_amt;

  // Named internal events
  assign cnt_wr    = lo_wr || hi_wr;
  assign advance   = ctrl.run && tick_i && !cnt_wr;
  assign frac_step = advance && ctrl.scale_on;
  assign step_amt  = ctrl.scale_on ? scaled_inc : INC_W'(1);

  sc_regs #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W),
    .SCALE_W(SCALE_W), .SCALE_RST(SCALE_W'(1) << FRAC_W)
  ) regs_i (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .count_i(count_o), .ctrl_o(ctrl), .scale_o(scale),
    .lo_wr_o(lo_wr), .hi_wr_o(hi_wr), .scale_load_o(scale_load),
    .rdata_o(rdata_o)
  );

  sc_accum #(.SCALE_W(SCALE_W), .FRAC_W(FRAC_W)) accum_i (
    .clk(clk), .rst_n(rst_n), .step_i(frac_step),
    .clear_i(cnt_wr || scale_load), .scale_i(scale), .inc_o(scaled_inc)
  );

  sc_count #(.CNT_W(CNT_W), .DATA_W(DATA_W), .INC_W(INC_W)) count_i (
    .clk(clk), .rst_n(rst_n), .adv_i(advance), .amt_i(step_amt),
    .lo_wr_i(lo_wr), .hi_wr_i(hi_wr), .wdata_i(wdata_i), .count_o(count_o)
  );

  // R2: a stopped counter does not move unless software writes it
  a_r2_hold_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl.run && !wr_en_i) |=> $stable(count_o));

  // R3: unscaled ticks add exactly one
  a_r3_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.run && !ctrl.scale_on && tick_i && !wr_en_i)
      |=> (count_o == $past(count_o) + CNT_W'(1)));

  // R4: a scaled tick never adds more than the integer range allows
  a_r4_step_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.run && ctrl.scale_on && tick_i && !wr_en_i)
      |=> ((count_o - $past(count_o)) < (CNT_W'(1) << INC_W)));
endmodule

// File: tb/sc_counter_top_tb_top.sv
module sc_counter_top_tb_top;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        tick_i = 0;
  logic        wr_en_i = 0;
  logic [4:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [63:0] count_o;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  sc_counter_top dut_i (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .wr_en_i(wr_en_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .count_o(count_o)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en_i = 1; addr_i = a; wdata_i = d;
    @(negedge clk);
    wr_en_i = 0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    addr_i = a;
    #1 d = rdata_o;
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tick_i = 1;
    repeat (n) @(negedge clk);
    tick_i = 0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    chk("R1 count", count_o, 0);
    rd(5'h00, d); chk("R1 ctrl", d, 0);
    rd(5'h10, d); chk("R1 scale", d, 32'h0100_0000);
    rd(5'h04, d); chk("R1 status", d, 1);
  endtask

  task automatic t_disabled;
    ticks(50);
    chk("R2 no move while stopped", count_o, 0);
  endtask

  task automatic t_unit;
    logic [31:0] d;
    wr(5'h00, 32'h1);
    rd(5'h04, d); chk("R9 status running", d, 0);
    rd(5'h00, d); chk("R5 ctrl readback", d, 1);
    ticks(100);
    chk("R3 100 ticks", count_o, 100);
    rd(5'h08, d); chk("R6 low read", d, 100);
    wr(5'h00, 32'h0);
    rd(5'h04, d); chk("R9 status halted", d, 1);
  endtask

  task automatic t_scaled;
    logic [31:0] d;
    wr(5'h10, 32'h0010_0000);
    wr(5'h08, 0);
    wr(5'h00, 32'hFFFF_FFFF);
    rd(5'h00, d); chk("R5 only bits 0 and 2", d, 5);
    ticks(160);
    chk("R4 one sixteenth", count_o, 10);
    wr(5'h10, 32'h0200_0000);
    rd(5'h10, d); chk("R8 scale write ignored", d, 32'h0010_0000);
    wr(5'h00, 0);
    wr(5'h10, 32'h0280_0000);
    wr(5'h08, 0);
    wr(5'h00, 5);
    ticks(4);
    chk("R4 scale 2.5 over 4", count_o, 10);
    wr(5'h00, 0);
  endtask

  task automatic t_frac_clear;
    wr(5'h10, 32'h0080_0000);
    wr(5'h08, 0);
    wr(5'h00, 5);
    ticks(1);
    chk("R4 half step", count_o, 0);
    wr(5'h08, 0);
    ticks(1);
    chk("R7 count write cleared fraction", count_o, 0);
    ticks(1);
    chk("R7 fraction carried", count_o, 1);
    wr(5'h00, 0);
    wr(5'h08, 0);
    wr(5'h00, 5);
    ticks(1);
    wr(5'h00, 0);
    wr(5'h10, 32'h0080_0000);
    wr(5'h00, 5);
    ticks(1);
    chk("R7 scale write cleared fraction", count_o, 0);
    wr(5'h00, 0);
  endtask

  task automatic t_halves;
    logic [31:0] d;
    wr(5'h0C, 32'h0000_0042);
    wr(5'h08, 32'hFFFF_FFFE);
    chk("R6 halves written", count_o, 64'h0000_0042_FFFF_FFFE);
    wr(5'h00, 1);
    ticks(3);
    chk("R6 carry into high", count_o, 64'h0000_0043_0000_0001);
    rd(5'h0C, d); chk("R6 high read", d, 32'h43);
    rd(5'h14, d); chk("R11 unmapped", d, 0);
    // R10: write during a tick
    @(negedge clk);
    tick_i = 1; wr_en_i = 1; addr_i = 5'h08; wdata_i = 32'h1234;
    @(negedge clk);
    tick_i = 0; wr_en_i = 0;
    chk("R10 write beats tick", count_o, 64'h0000_0043_0000_1234);
    wr(5'h00, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_disabled();
    t_unit();
    t_scaled();
    t_frac_clear();
    t_halves();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule